// File: doc/BRIEF.md
# Multi-Locality Ownership Arbiter

This block decides which of several localities owns a shared security-device register interface at any moment. Each locality has its own byte-wide access register. The locality of a write or read comes from a three-bit address field, which maps to address bits [14:12] of the system bus. Software takes the interface in one of two ways. It can ask for it politely: the request is granted at once if nobody holds it, and otherwise it is queued until release. It can also take it by force with a seize, which works only when the seizer outranks the current holder.

An ownership change from a polite release with waiting requesters, or from a seize, is not made at once. The block first emits a one-cycle abort request to the downstream command engine. The request names the locality that is giving up the interface and the one that will receive it. The change takes effect when the engine answers with an abort-done pulse. A release with nobody waiting, and a request while the interface is free, take effect on the next clock edge without an abort. Every change of owner can raise a one-cycle locality-changed strobe. The strobe is gated by an interrupt-enable bit for the new owner, which is supplied from outside the block.

Top module: `locality_arbiter`

## Requirements
- R1: After reset the owner reads as 0xFF (none), each of the five localities' access registers reads 0x80, and neither abort_req nor loc_chg_irq is high.
- R2: The access register layout is: bit 7 register-valid (always 1), bit 5 this locality is the owner, bit 4 been-seized, bit 2 another locality has a request pending, bit 1 own request flag, bit 3 seize (always reads 0). Bits 6 and 0 read 0. A read of locality 5 to 7 returns 0xFF.
- R3: A write with bit 1 set, while no locality owns the interface, makes the writer the owner on the next edge.
- R4: A write with bit 1 set, while a different locality owns the interface, sets the writer's request flag. Every other locality then sees its pending bit set.
- R5: When the owner writes bit 5 and no request flag is set, the owner becomes 0xFF on the next edge, with no abort and no strobe.
- R6: When the owner writes bit 5 and request flags are set, abort_req pulses for one cycle with abort_from equal to the owner and abort_to equal to the highest-numbered requester. The owner holds until abort_done. At abort_done the requester takes over, and the old owner loses its owner and request bits.
- R7: A write of bit 5 by a locality that does not own the interface only clears that locality's request flag.
- R8: A write with bit 3 set is accepted only when no locality owns the interface, or when the writer is numbered above the owner. An accepted seize pulses abort_req with abort_from equal to the owner (0xFF if none) and abort_to equal to the writer. It cancels seizes pending from lower localities.
- R9: A seize is ignored when the writer already has one pending, or when a higher locality has one pending. Bits 1 and 5 of any write that carries bit 3 have no effect.
- R10: When a seize completes, the old owner gets been-seized set, and the new owner's request and seize flags are cleared. Writing bit 4 as 1 clears the writer's been-seized flag.
- R11: Writes from locality 4 and from localities 5 to 7 change no state and raise no abort.
- R12: loc_chg_irq pulses for one cycle on the edge after the owner changes to a valid locality, and only when irq_en of the new owner is 1.
- R13: In a cycle where abort_done completes a pending switch, a write that arrives at the same time is ignored. abort_done with no switch pending changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Access register write strobe |
| wr_addr | input | 3 | Locality field of the write address (bus bits 14:12) |
| wr_data | input | 8 | Write data byte |
| rd_addr | input | 3 | Locality field of the read address |
| rd_data | output | 8 | Access register value of the read locality |
| irq_en | input | 5 | Per-locality enable for the locality-changed strobe |
| abort_done | input | 1 | Command engine has finished aborting |
| abort_req | output | 1 | One-cycle abort request |
| abort_from | output | 8 | Locality giving up ownership (0xFF for none) |
| abort_to | output | 8 | Locality that will own after the abort |
| active_loc | output | 8 | Current owner, 0xFF for none |
| loc_chg_irq | output | 1 | One-cycle locality-changed strobe |

## Verification
Every state change is captured on the clock edge that samples the write or abort_done. active_loc, abort_req, abort_from, abort_to and loc_chg_irq are all registered, so each one is due exactly one edge after its stimulus. rd_data is combinational from the registered flags, so it shows the new state in that same cycle. The bench drives each stimulus for one edge, removes it just after that edge, and samples all results at the following falling edge. This catches the one-cycle pulses while they are high and confirms that the owner has not moved early while an abort is pending.

// File: rtl/loc_arb_pkg.sv
package loc_arb_pkg;
  localparam int          ACC_W   = 8;
  localparam int          B_REQ   = 1;
  localparam int          B_PEND  = 2;
  localparam int          B_SEIZE = 3;
  localparam int          B_BS    = 4;
  localparam int          B_ACT   = 5;
  localparam int          B_VALID = 7;
  localparam logic [7:0]  NO_LOC  = 8'hFF;
endpackage

// File: rtl/loc_arb_pick.sv
module loc_arb_pick #(
  parameter int NUM_LOC = 5
) (
  input  logic [NUM_LOC-1:0] vec,
  output logic               found,
  output logic [7:0]         idx
);
  import loc_arb_pkg::*;
  always_comb begin
    found = 1'b0;
    idx   = NO_LOC;
    for (int i = 0; i < NUM_LOC; i++) begin
      if (vec[i]) begin
        found = 1'b1;
        idx   = 8'(i);
      end
    end
  end
endmodule

// File: rtl/loc_arb_rdmux.sv
module loc_arb_rdmux #(
  parameter int NUM_LOC = 5
) (
  input  logic [7:0]         rd_loc,
  input  logic [7:0]         active_q,
  input  logic [NUM_LOC-1:0] req_q,
  input  logic [NUM_LOC-1:0] bs_q,
  output logic [7:0]         rd_data
);
  import loc_arb_pkg::*;
  localparam logic [7:0] NUM_L8 = 8'(NUM_LOC);
  always_comb begin
    rd_data = 8'hFF;
    if (rd_loc < NUM_L8) begin
      rd_data          = '0;
      rd_data[B_VALID] = 1'b1;
      rd_data[B_ACT]   = (active_q == rd_loc);
      for (int j = 0; j < NUM_LOC; j++) begin
        if (8'(j) == rd_loc) begin
          rd_data[B_REQ] = req_q[j];
          rd_data[B_BS]  = bs_q[j];
        end else if (req_q[j]) begin
          rd_data[B_PEND] = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/loc_arb_ctrl.sv
module loc_arb_ctrl #(
  parameter int NUM_LOC    = 5,
  parameter int LOCKED_LOC = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [7:0]         wr_loc,
  input  logic               d_req_in,
  input  logic               d_seize,
  input  logic               d_bs,
  input  logic               d_act_in,
  input  logic               abort_done,
  input  logic [NUM_LOC-1:0] irq_en,
  input  logic               hi_found,
  input  logic [7:0]         hi_idx,
  output logic [7:0]         active_q,
  output logic [NUM_LOC-1:0] req_q,
  output logic [NUM_LOC-1:0] bs_q,
  output logic               abort_req,
  output logic [7:0]         abort_from,
  output logic [7:0]         abort_to,
  output logic               loc_chg_irq
);
  import loc_arb_pkg::*;
  localparam logic [7:0] NUM_L8 = 8'(NUM_LOC);
  localparam logic [7:0] LCK_L8 = 8'(LOCKED_LOC);

  logic [NUM_LOC-1:0] seize_q, req_d, seize_d, bs_d;
  logic [7:0]         act_d, next_q, next_d, ab_from_d, ab_to_d, sw_to;
  logic               pend_q, pend_d, ab_go, sw_go, irq_d;
  logic               own_seize, hi_seize, change, to_valid, is_sz;

  wire wr_ok     = wr_en && (wr_loc < NUM_L8) && (wr_loc != LCK_L8);
  wire act_valid = active_q < NUM_L8;
  wire is_owner  = act_valid && (active_q == wr_loc);
  wire d_req     = d_req_in & ~d_seize;
  wire d_act     = d_act_in & ~d_seize;

  always_comb begin
    req_d = req_q;  seize_d = seize_q;  bs_d = bs_q;  act_d = active_q;
    pend_d = pend_q;  next_d = next_q;
    ab_go = 1'b0;  ab_from_d = '0;  ab_to_d = '0;
    sw_go = 1'b0;  sw_to = NO_LOC;  irq_d = 1'b0;
    own_seize = 1'b0;  hi_seize = 1'b0;
    change = 1'b0;  to_valid = 1'b0;  is_sz = 1'b0;
    if (abort_done && pend_q) begin
      sw_go  = 1'b1;
      sw_to  = next_q;
      pend_d = 1'b0;
    end else if (wr_ok) begin
      if (d_act) begin
        if (is_owner) begin
          if (hi_found) begin
            ab_go = 1'b1;  ab_from_d = wr_loc;  ab_to_d = hi_idx;
          end else begin
            sw_go = 1'b1;  sw_to = NO_LOC;
          end
        end else begin
          for (int j = 0; j < NUM_LOC; j++)
            if (8'(j) == wr_loc) req_d[j] = 1'b0;
        end
      end
      if (d_bs) begin
        for (int j = 0; j < NUM_LOC; j++)
          if (8'(j) == wr_loc) bs_d[j] = 1'b0;
      end
      if (d_seize) begin
        for (int j = 0; j < NUM_LOC; j++) begin
          if (8'(j) == wr_loc) own_seize = seize_q[j];
          if (8'(j) > wr_loc && seize_q[j]) hi_seize = 1'b1;
        end
        if ((!act_valid || wr_loc > active_q) && !own_seize && !hi_seize) begin
          for (int j = 0; j < NUM_LOC; j++) begin
            if (8'(j) < wr_loc)       seize_d[j] = 1'b0;
            else if (8'(j) == wr_loc) seize_d[j] = 1'b1;
          end
          ab_go = 1'b1;  ab_from_d = active_q;  ab_to_d = wr_loc;
        end
      end
      if (d_req && !is_owner) begin
        if (act_valid) begin
          for (int j = 0; j < NUM_LOC; j++)
            if (8'(j) == wr_loc) req_d[j] = 1'b1;
        end else begin
          sw_go = 1'b1;  sw_to = wr_loc;
        end
      end
      if (ab_go) begin
        pend_d = 1'b1;  next_d = ab_to_d;  sw_go = 1'b0;
      end
    end
    if (sw_go) begin
      change   = (active_q != sw_to);
      to_valid = (sw_to < NUM_L8);
      for (int j = 0; j < NUM_LOC; j++)
        if (8'(j) == sw_to) is_sz = seize_d[j];
      if (change && act_valid) begin
        for (int j = 0; j < NUM_LOC; j++) begin
          if (8'(j) == active_q) begin
            if (to_valid && is_sz) bs_d[j]  = 1'b1;
            else                   req_d[j] = 1'b0;
          end
        end
      end
      act_d = sw_to;
      for (int j = 0; j < NUM_LOC; j++) begin
        if (8'(j) == sw_to) begin
          req_d[j]   = 1'b0;
          seize_d[j] = 1'b0;
          irq_d      = change && irq_en[j];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q    <= NO_LOC;
      req_q       <= '0;
      seize_q     <= '0;
      bs_q        <= '0;
      pend_q      <= 1'b0;
      next_q      <= NO_LOC;
      abort_req   <= 1'b0;
      abort_from  <= NO_LOC;
      abort_to    <= NO_LOC;
      loc_chg_irq <= 1'b0;
    end else begin
      active_q    <= act_d;
      req_q       <= req_d;
      seize_q     <= seize_d;
      bs_q        <= bs_d;
      pend_q      <= pend_d;
      next_q      <= next_d;
      abort_req   <= ab_go;
      loc_chg_irq <= irq_d;
      if (ab_go) begin
        abort_from <= ab_from_d;
        abort_to   <= ab_to_d;
      end
    end
  end
endmodule

// File: rtl/locality_arbiter.sv
module locality_arbiter #(
  parameter int NUM_LOC    = 5,
  parameter int LOC_W      = 3,
  parameter int LOCKED_LOC = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [LOC_W-1:0]   wr_addr,
  input  logic [7:0]         wr_data,
  input  logic [LOC_W-1:0]   rd_addr,
  output logic [7:0]         rd_data,
  input  logic [NUM_LOC-1:0] irq_en,
  input  logic               abort_done,
  output logic               abort_req,
  output logic [7:0]         abort_from,
  output logic [7:0]         abort_to,
  output logic [7:0]         active_loc,
  output logic               loc_chg_irq
);
  import loc_arb_pkg::*;
  localparam int PAD_W = 8 - LOC_W;

  logic               rst_meta, rst_sync;
  logic [NUM_LOC-1:0] req_q, bs_q;
  logic               hi_found;
  logic [7:0]         hi_idx;

  wire [7:0] wr_loc = {{PAD_W{1'b0}}, wr_addr};
  wire [7:0] rd_loc = {{PAD_W{1'b0}}, rd_addr};
  wire unused_data_bits = ^{wr_data[7:6], wr_data[2], wr_data[0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  loc_arb_pick #(.NUM_LOC(NUM_LOC)) u_pick (
    .vec(req_q), .found(hi_found), .idx(hi_idx)
  );

  loc_arb_ctrl #(.NUM_LOC(NUM_LOC), .LOCKED_LOC(LOCKED_LOC)) u_ctrl (
    .clk(clk), .rst_n(rst_sync), .wr_en(wr_en), .wr_loc(wr_loc),
    .d_req_in(wr_data[B_REQ]), .d_seize(wr_data[B_SEIZE]),
    .d_bs(wr_data[B_BS]), .d_act_in(wr_data[B_ACT]),
    .abort_done(abort_done), .irq_en(irq_en),
    .hi_found(hi_found), .hi_idx(hi_idx),
    .active_q(active_loc), .req_q(req_q), .bs_q(bs_q),
    .abort_req(abort_req), .abort_from(abort_from), .abort_to(abort_to),
    .loc_chg_irq(loc_chg_irq)
  );

  loc_arb_rdmux #(.NUM_LOC(NUM_LOC)) u_rd (
    .rd_loc(rd_loc), .active_q(active_loc), .req_q(req_q), .bs_q(bs_q),
    .rd_data(rd_data)
  );
endmodule

// File: rtl/locality_arbiter_chk.sv
module locality_arbiter_chk #(
  parameter int NUM_LOC    = 5,
  parameter int LOC_W      = 3,
  parameter int LOCKED_LOC = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [LOC_W-1:0] wr_addr,
  input logic             abort_done,
  input logic             abort_req,
  input logic [7:0]       abort_from,
  input logic [7:0]       abort_to,
  input logic [7:0]       active_loc,
  input logic             loc_chg_irq
);
  localparam logic [7:0] NUM_L8 = 8'(NUM_LOC);

  // R5: the owner is always a real locality or none
  a_r5_owner_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (active_loc < NUM_L8) || (active_loc == 8'hFF));

  // R12: the strobe follows a change to a valid owner
  a_r12_irq_on_change: assert property (@(posedge clk) disable iff (!rst_n)
    loc_chg_irq |-> (active_loc != $past(active_loc)) && (active_loc < NUM_L8));

  // R6: an abort names two different localities and a valid target
  a_r6_abort_pair: assert property (@(posedge clk) disable iff (!rst_n)
    abort_req |-> (abort_from != abort_to) && (abort_to < NUM_L8));

  // R6: the owner does not move in the cycle an abort is issued
  a_r6_abort_holds_owner: assert property (@(posedge clk) disable iff (!rst_n)
    abort_req |-> $stable(active_loc));

  // R11: a write from the locked locality leaves the owner alone
  a_r11_locked_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !abort_done && (wr_addr == LOC_W'(LOCKED_LOC)))
      |=> ($stable(active_loc) && !abort_req));
endmodule

bind locality_arbiter locality_arbiter_chk #(
  .NUM_LOC(NUM_LOC), .LOC_W(LOC_W), .LOCKED_LOC(LOCKED_LOC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .abort_done(abort_done), .abort_req(abort_req), .abort_from(abort_from),
  .abort_to(abort_to), .active_loc(active_loc), .loc_chg_irq(loc_chg_irq)
);

// File: tb/locality_arbiter_test.sv
`timescale 1ns/1ps
module locality_arbiter_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic [4:0] irq_en = 5'h1F;
  logic       abort_done = 1'b0;
  logic       abort_req, loc_chg_irq;
  logic [7:0] abort_from, abort_to, active_loc;
  int tests = 0, fails = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  locality_arbiter uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .irq_en(irq_en), .abort_done(abort_done), .abort_req(abort_req),
    .abort_from(abort_from), .abort_to(abort_to), .active_loc(active_loc),
    .loc_chg_irq(loc_chg_irq)
  );

  typedef struct packed {
    logic [3:0] tag;
    logic       dn;
    logic [2:0] loc;
    logic [7:0] data;
    logic [7:0] e_act;
    logic       e_ab;
    logic [7:0] e_from;
    logic [7:0] e_to;
    logic       e_irq;
    logic [7:0] e_rd;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t TBL [NV] = '{
    '{4'd3,  1'b0, 3'd0, 8'h02, 8'h00, 1'b0, 8'h00, 8'h00, 1'b1, 8'hA0}, // R3 free -> owner
    '{4'd4,  1'b0, 3'd2, 8'h02, 8'h00, 1'b0, 8'h00, 8'h00, 1'b0, 8'h82}, // R4 queue
    '{4'd4,  1'b0, 3'd1, 8'h02, 8'h00, 1'b0, 8'h00, 8'h00, 1'b0, 8'h86}, // R4 pending seen
    '{4'd6,  1'b0, 3'd0, 8'h20, 8'h00, 1'b1, 8'h00, 8'h02, 1'b0, 8'hA4}, // R6 release
    '{4'd6,  1'b1, 3'd0, 8'h00, 8'h02, 1'b0, 8'h00, 8'h00, 1'b1, 8'h84}, // R6 done
    '{4'd7,  1'b0, 3'd1, 8'h20, 8'h02, 1'b0, 8'h00, 8'h00, 1'b0, 8'h80}, // R7
    '{4'd8,  1'b0, 3'd3, 8'h08, 8'h02, 1'b1, 8'h02, 8'h03, 1'b0, 8'h80}, // R8 seize
    '{4'd8,  1'b0, 3'd1, 8'h08, 8'h02, 1'b0, 8'h00, 8'h00, 1'b0, 8'h80}, // R8 low seize
    '{4'd9,  1'b0, 3'd3, 8'h08, 8'h02, 1'b0, 8'h00, 8'h00, 1'b0, 8'h80}, // R9 own pending
    '{4'd10, 1'b1, 3'd2, 8'h00, 8'h03, 1'b0, 8'h00, 8'h00, 1'b1, 8'h90}, // R10 seized
    '{4'd10, 1'b0, 3'd2, 8'h10, 8'h03, 1'b0, 8'h00, 8'h00, 1'b0, 8'h80}, // R10 clear
    '{4'd9,  1'b0, 3'd1, 8'h2A, 8'h03, 1'b0, 8'h00, 8'h00, 1'b0, 8'h80}, // R9 masked bits
    '{4'd11, 1'b0, 3'd4, 8'h02, 8'h03, 1'b0, 8'h00, 8'h00, 1'b0, 8'h80}, // R11 locked
    '{4'd5,  1'b0, 3'd3, 8'h20, 8'hFF, 1'b0, 8'h00, 8'h00, 1'b0, 8'h80}, // R5 to none
    '{4'd8,  1'b0, 3'd1, 8'h08, 8'hFF, 1'b1, 8'hFF, 8'h01, 1'b0, 8'h80}, // R8 from none
    '{4'd8,  1'b1, 3'd1, 8'h00, 8'h01, 1'b0, 8'h00, 8'h00, 1'b1, 8'hA0}, // R8 done
    '{4'd4,  1'b0, 3'd0, 8'h02, 8'h01, 1'b0, 8'h00, 8'h00, 1'b0, 8'h82}, // R4
    '{4'd6,  1'b0, 3'd1, 8'h22, 8'h01, 1'b1, 8'h01, 8'h00, 1'b0, 8'hA4}, // R6
    '{4'd6,  1'b1, 3'd1, 8'h00, 8'h00, 1'b0, 8'h00, 8'h00, 1'b1, 8'h80}  // R6 done
  };

  task automatic chk(input string tag, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
    end
  endtask

  task automatic drive(input bit wr, input bit dn, input int loc, input logic [7:0] data);
    @(negedge clk);
    wr_en = wr;  abort_done = dn;
    wr_addr = 3'(loc);  rd_addr = 3'(loc);  wr_data = data;
    @(posedge clk);
    #1;
    wr_en = 1'b0;  abort_done = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      tests++;  fails++;
      $display("FAIL watchdog: got hang expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1", "owner", active_loc, 8'hFF);
    chk("R1", "abort", abort_req, 1'b0);
    chk("R1", "irq", loc_chg_irq, 1'b0);
    for (int l = 0; l < 5; l++) begin
      rd_addr = 3'(l);
      #0.1;
      chk("R1", "access", rd_data, 8'h80);
    end
    rd_addr = 3'd5;  #0.1;
    chk("R2", "invalid read", rd_data, 8'hFF);

    for (int i = 0; i < NV; i++) begin
      string t;
      t = $sformatf("R%0d step%0d", TBL[i].tag, i);
      drive(!TBL[i].dn, TBL[i].dn, int'(TBL[i].loc), TBL[i].data);
      chk(t, "owner", active_loc, TBL[i].e_act);
      chk(t, "abort", abort_req, TBL[i].e_ab);
      if (TBL[i].e_ab) begin
        chk(t, "from", abort_from, TBL[i].e_from);
        chk(t, "to", abort_to, TBL[i].e_to);
      end
      chk(t, "irq", loc_chg_irq, TBL[i].e_irq);
      chk(t, "access", rd_data, TBL[i].e_rd);
    end

    // R12: no strobe when the new owner has its enable clear
    irq_en = 5'b11011;
    drive(1'b1, 1'b0, 0, 8'h20);
    chk("R5", "owner", active_loc, 8'hFF);
    drive(1'b1, 1'b0, 2, 8'h02);
    chk("R12", "owner", active_loc, 8'h02);
    chk("R12", "irq gated", loc_chg_irq, 1'b0);
    irq_en = 5'h1F;

    // R13: write in the same cycle as abort_done is dropped
    drive(1'b1, 1'b0, 3, 8'h08);
    chk("R8", "abort", abort_req, 1'b1);
    drive(1'b1, 1'b1, 1, 8'h02);
    chk("R13", "owner", active_loc, 8'h03);
    chk("R13", "irq", loc_chg_irq, 1'b1);
    chk("R13", "write dropped", rd_data, 8'h80);
    // R13: stray abort_done
    drive(1'b0, 1'b1, 3, 8'h00);
    chk("R13", "stray owner", active_loc, 8'h03);
    chk("R13", "stray irq", loc_chg_irq, 1'b0);

    // R11: write to a nonexistent locality
    drive(1'b1, 1'b0, 6, 8'h20);
    chk("R11", "owner", active_loc, 8'h03);
    chk("R11", "abort", abort_req, 1'b0);
    chk("R2", "invalid read", rd_data, 8'hFF);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule